// File: doc/BRIEF.md
# Precision Time Event Timestamp Capture Unit

This block keeps the capture times of precision-time event messages for one port, with one queue for the receive direction and one for the transmit direction. A packet parser elsewhere pulses a capture input when an event message crosses the line. It presents the current time from the time counter and the message's 16-bit sequence identifier alongside the pulse. The block stores these three values as one entry at the tail of that direction's queue.

Software reads the entry at the head of a queue through a small register window. It reads the two seconds halves and the two nanoseconds halves first, then the sequence identifier. Reading the sequence identifier retires the entry. An info register gives both occupancy counts so software can keep draining while a count is non-zero. A capture that finds its queue full is lost and is flagged as an overflow. An interrupt output signals waiting timestamps and overflows, subject to a four-bit enable mask. The overflow flags clear when software reads the status register.

Register map (16-bit data, 4-bit address): 0x0 enable, 0x1 status, 0x2 info. Receive head: 0x4 seconds high, 0x5 seconds low, 0x6 nanoseconds high, 0x7 nanoseconds low, 0x8 sequence ID. Transmit head: 0x9 to 0xD in the same field order. Any other address reads zero.

Top module: `ts_capture_unit`

## Requirements
- R1: After reset both queues are empty, the enable mask and all status bits are zero, the interrupt output is low, and every register reads zero.
- R2: A capture pulse appends {current seconds, current nanoseconds, sequence ID} to its direction's queue, which holds up to 8 entries in arrival order. The info register (0x2) reports the transmit count in bits 11:8 and the receive count in bits 3:0, with the other bits zero.
- R3: The head registers return the head entry. Seconds high is seconds[31:16] and seconds low is seconds[15:0]. Nanoseconds high carries nanoseconds[29:16] in bits 13:0 with bits 15:14 zero, and nanoseconds low is nanoseconds[15:0]. Read data is combinational from the address.
- R4: A read of a direction's sequence-ID register (0x8 receive, 0xD transmit) returns the head sequence ID and removes the head entry at that clock edge. Reads of the other head registers do not change the queue.
- R5: When a queue is empty, its five head registers read zero, and a sequence-ID read leaves its count at zero.
- R6: A capture into a full queue with no pop at the same edge is dropped and the queue is unchanged. If enable bit 1 (receive) or 3 (transmit) is set, the drop latches that direction's overflow flag. A capture at the same edge as a pop of a full queue is accepted.
- R7: The enable register (0x0) is written through bits 3:0 and reads back in bits 3:0. Bit 0 is receive available, bit 1 receive overflow, bit 2 transmit available and bit 3 transmit overflow.
- R8: Status bit 0 (or 2) reads 1 exactly when the receive (or transmit) queue is non-empty and enable bit 0 (or 2) is set.
- R9: Status bits 1 and 3 read the latched overflow flag ANDed with its enable bit. A read of the status register (0x1) returns the current value and clears both latched flags, except when a drop occurs at the same edge, in which case that flag stays set.
- R10: The interrupt output is high exactly when some status bit is 1.
- R11: The two directions are independent: captures, pops and drops in one never alter the other's count, head or flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_cap_i | input | 1 | Receive capture pulse |
| rx_seq_i | input | 16 | Receive message sequence ID |
| tx_cap_i | input | 1 | Transmit capture pulse |
| tx_seq_i | input | 16 | Transmit message sequence ID |
| now_sec_i | input | 32 | Current time, seconds |
| now_nsec_i | input | 30 | Current time, nanoseconds |
| reg_rd_i | input | 1 | Register read strobe (side effects at clock edge) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 4 | Write data (enable mask) |
| reg_rdata_o | output | 16 | Read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after the full-queue boundary. A ninth capture must be lost without disturbing the head, and a design that overwrote the oldest entry would return a wrong sequence ID on drain. A capture at the same edge as a pop of a full queue must be accepted, and one that rejected it would report a count of 7. It also checks a status read at the same edge as a drop, where a design that let the clear win would lose the overflow. It checks sequence-ID reads of an empty queue, where a design that popped blindly would wrap its pointers and underflow the count. It checks that reads of the other head fields never pop.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;

    parameter int SEC_W   = 32;
    parameter int NS_W    = 30;
    parameter int SEQ_W   = 16;
    parameter int REG_W   = 16;
    parameter int ADDR_W  = 4;
    parameter int NUM_DIR = 2;
    parameter int CNT_FIELD_W = 4;

    localparam int EN_W   = 2 * NUM_DIR;
    localparam int DIR_RX = 0;
    localparam int DIR_TX = 1;

    localparam logic [ADDR_W-1:0] A_EN       = 4'h0;
    localparam logic [ADDR_W-1:0] A_STS      = 4'h1;
    localparam logic [ADDR_W-1:0] A_INFO     = 4'h2;
    localparam logic [ADDR_W-1:0] A_RX_BASE  = 4'h4;
    localparam logic [ADDR_W-1:0] A_TX_BASE  = 4'h9;
    localparam logic [ADDR_W-1:0] HEAD_LAST  = 4'h4;

    localparam int INFO_TX_LSB = 8;
    localparam int INFO_RX_LSB = 0;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  nsec;
        logic [SEQ_W-1:0] seq;
    } ts_entry_t;

    typedef enum logic [2:0] {
        F_SEC_HI = 3'd0,
        F_SEC_LO = 3'd1,
        F_NS_HI  = 3'd2,
        F_NS_LO  = 3'd3,
        F_SEQ    = 3'd4
    } head_field_e;

    function automatic logic [ADDR_W-1:0] head_base(input int dir);
        return (dir == DIR_RX) ? A_RX_BASE : A_TX_BASE;
    endfunction

    function automatic logic [ADDR_W-1:0] seq_addr(input int dir);
        return head_base(dir) + HEAD_LAST;
    endfunction

    function automatic logic [REG_W-1:0] head_word(input ts_entry_t e,
                                                   input head_field_e f);
        logic [REG_W-1:0] w;
        case (f)
            F_SEC_HI: w = e.sec[SEC_W-1:16];
            F_SEC_LO: w = e.sec[15:0];
            F_NS_HI:  w = REG_W'(e.nsec[NS_W-1:16]);
            F_NS_LO:  w = e.nsec[15:0];
            F_SEQ:    w = e.seq;
            default:  w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/ts_entry_fifo.sv
module ts_entry_fifo
    import ts_cap_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             push_i,
    input  ts_entry_t                        push_data_i,
    input  logic                             pop_i,
    output ts_entry_t                        head_o,
    output logic [$clog2(DEPTH+1)-1:0]       count_o,
    output logic                             drop_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    ts_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             pop_ok, push_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    assign pop_ok  = pop_i && (count_q != '0);
    assign push_ok = push_i && ((count_q != CNT_FULL) || pop_ok);
    assign drop_o  = push_i && !push_ok;
    assign count_o = count_q;
    assign head_o  = (count_q == '0) ? '0 : mem[rd_ptr_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr_q <= ptr_next(wr_ptr_q);
            end
            if (pop_ok) begin
                rd_ptr_q <= ptr_next(rd_ptr_q);
            end
            case ({push_ok, pop_ok})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr_q] <= push_data_i;
        end
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_FULL); // R2

    AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (count_q == '0 && pop_i && !push_i) |=> (count_q == '0)); // R5

    AST_POP_STEP: assert property (@(posedge clk) disable iff (rst)
        (count_q != '0 && pop_i && !push_i) |=> (count_q == $past(count_q) - 1'b1)); // R4

    AST_FULL_DROP_KEEP: assert property (@(posedge clk) disable iff (rst)
        (count_q == CNT_FULL && push_i && !pop_i) |=> (count_q == CNT_FULL && $stable(head_o))); // R6

endmodule

// File: rtl/ts_irq_ctrl.sv
module ts_irq_ctrl
    import ts_cap_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en_wr_i,
    input  logic [EN_W-1:0]    en_wdata_i,
    input  logic               sts_rd_i,
    input  logic [NUM_DIR-1:0] nonempty_i,
    input  logic [NUM_DIR-1:0] drop_i,
    output logic [EN_W-1:0]    en_o,
    output logic [EN_W-1:0]    sts_o,
    output logic               irq_o
);
    logic [EN_W-1:0]    en_q;
    logic [NUM_DIR-1:0] ovf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (en_wr_i) begin
            en_q <= en_wdata_i;
        end
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        always_ff @(posedge clk) begin
            if (rst) begin
                ovf_q[d] <= 1'b0;
            end else if (drop_i[d] && en_q[2*d+1]) begin
                ovf_q[d] <= 1'b1;
            end else if (sts_rd_i) begin
                ovf_q[d] <= 1'b0;
            end
        end

        assign sts_o[2*d]   = nonempty_i[d] & en_q[2*d];
        assign sts_o[2*d+1] = ovf_q[d] & en_q[2*d+1];

        AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
            (drop_i[d] && en_q[2*d+1] && !en_wr_i) |=> sts_o[2*d+1]); // R6
    end

    assign en_o  = en_q;
    assign irq_o = |sts_o;

    AST_STS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (sts_rd_i && drop_i == '0) |=> (ovf_q == '0)); // R9

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> !irq_o); // R10

endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
    import ts_cap_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_cap_i,
    input  logic [SEQ_W-1:0]  rx_seq_i,
    input  logic              tx_cap_i,
    input  logic [SEQ_W-1:0]  tx_seq_i,
    input  logic [SEC_W-1:0]  now_sec_i,
    input  logic [NS_W-1:0]   now_nsec_i,
    input  logic              reg_rd_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [EN_W-1:0]   reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    output logic              irq_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [NUM_DIR-1:0] cap, pop, drop, nonempty;
    logic [SEQ_W-1:0]   seq_in [NUM_DIR];
    ts_entry_t          head   [NUM_DIR];
    logic [CNT_W-1:0]   cnt    [NUM_DIR];
    logic [EN_W-1:0]    en, sts;
    logic               sts_rd;

    assign cap[DIR_RX]    = rx_cap_i;
    assign cap[DIR_TX]    = tx_cap_i;
    assign seq_in[DIR_RX] = rx_seq_i;
    assign seq_in[DIR_TX] = tx_seq_i;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_q
        ts_entry_t wr_entry;

        assign wr_entry    = '{sec: now_sec_i, nsec: now_nsec_i, seq: seq_in[d]};
        assign pop[d]      = reg_rd_i && (reg_addr_i == seq_addr(d));
        assign nonempty[d] = (cnt[d] != '0);

        ts_entry_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk        (clk),
            .rst        (rst),
            .push_i     (cap[d]),
            .push_data_i(wr_entry),
            .pop_i      (pop[d]),
            .head_o     (head[d]),
            .count_o    (cnt[d]),
            .drop_o     (drop[d])
        );
    end

    assign sts_rd = reg_rd_i && (reg_addr_i == A_STS);

    ts_irq_ctrl u_irq (
        .clk       (clk),
        .rst       (rst),
        .en_wr_i   (reg_wr_i && (reg_addr_i == A_EN)),
        .en_wdata_i(reg_wdata_i),
        .sts_rd_i  (sts_rd),
        .nonempty_i(nonempty),
        .drop_i    (drop),
        .en_o      (en),
        .sts_o     (sts),
        .irq_o     (irq_o)
    );

    always_comb begin
        logic [ADDR_W-1:0] ofs;
        reg_rdata_o = '0;
        ofs         = '0;
        if (reg_addr_i == A_EN) begin
            reg_rdata_o = REG_W'(en);
        end else if (reg_addr_i == A_STS) begin
            reg_rdata_o = REG_W'(sts);
        end else if (reg_addr_i == A_INFO) begin
            reg_rdata_o[INFO_TX_LSB +: CNT_FIELD_W] = CNT_FIELD_W'(cnt[DIR_TX]);
            reg_rdata_o[INFO_RX_LSB +: CNT_FIELD_W] = CNT_FIELD_W'(cnt[DIR_RX]);
        end
        for (int d = 0; d < NUM_DIR; d++) begin
            if (reg_addr_i >= head_base(d) && reg_addr_i <= seq_addr(d)) begin
                ofs         = reg_addr_i - head_base(d);
                reg_rdata_o = head_word(head[d], head_field_e'(ofs[2:0]));
            end
        end
    end

    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr_i == seq_addr(DIR_RX) && cnt[DIR_RX] == '0) |-> (reg_rdata_o == '0)); // R5

endmodule

// File: tb/ts_capture_unit_tb.sv
module ts_capture_unit_tb;
    import ts_cap_pkg::*;

    logic              clk = 1'b0;
    logic              rst;
    logic              rx_cap, tx_cap, reg_rd, reg_wr;
    logic [SEQ_W-1:0]  rx_seq, tx_seq;
    logic [SEC_W-1:0]  now_sec;
    logic [NS_W-1:0]   now_nsec;
    logic [ADDR_W-1:0] reg_addr;
    logic [EN_W-1:0]   reg_wdata;
    logic [REG_W-1:0]  reg_rdata;
    logic              irq;

    int n_checks = 0;
    int n_fail   = 0;

    ts_entry_t  mq [NUM_DIR][$];
    logic [3:0] m_en;
    bit         m_ovf [NUM_DIR];

    always #4 clk = ~clk;

    ts_capture_unit u_dut (
        .clk(clk), .rst(rst),
        .rx_cap_i(rx_cap), .rx_seq_i(rx_seq),
        .tx_cap_i(tx_cap), .tx_seq_i(tx_seq),
        .now_sec_i(now_sec), .now_nsec_i(now_nsec),
        .reg_rd_i(reg_rd), .reg_wr_i(reg_wr),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    function automatic logic [3:0] exp_sts();
        logic [3:0] s;
        for (int d = 0; d < NUM_DIR; d++) begin
            s[2*d]   = (mq[d].size() > 0) && m_en[2*d];
            s[2*d+1] = m_ovf[d] && m_en[2*d+1];
        end
        return s;
    endfunction

    function automatic logic [15:0] exp_read(input logic [3:0] a);
        ts_entry_t e;
        int d;
        int f;
        if (a == 4'h0) return {12'h0, m_en};
        if (a == 4'h1) return {12'h0, exp_sts()};
        if (a == 4'h2) return {4'h0, 4'(mq[1].size()), 4'h0, 4'(mq[0].size())};
        if (a >= 4'h4 && a <= 4'h8) begin d = 0; f = int'(a) - 4; end
        else if (a >= 4'h9 && a <= 4'hD) begin d = 1; f = int'(a) - 9; end
        else return 16'h0;
        if (mq[d].size() == 0) return 16'h0;
        e = mq[d][0];
        case (f)
            0: return e.sec[31:16];
            1: return e.sec[15:0];
            2: return {2'b00, e.nsec[29:16]};
            3: return e.nsec[15:0];
            default: return e.seq;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] a);
        if (a == 4'h0) return "R7";
        if (a == 4'h1) return "R9";
        if (a == 4'h2) return "R2";
        if (a == 4'h8 || a == 4'hD) return "R4";
        if (a >= 4'h4 && a <= 4'hC) return "R3";
        return "R1";
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input bit rxc, input bit txc,
                        input bit rd, input logic [3:0] a,
                        input bit wr, input logic [3:0] wd);
        ts_entry_t ent [NUM_DIR];
        bit        capv [NUM_DIR];
        bit        drp  [NUM_DIR];
        @(negedge clk);
        rx_cap = rxc; tx_cap = txc;
        rx_seq = 16'($urandom); tx_seq = 16'($urandom);
        now_sec = $urandom; now_nsec = 30'($urandom);
        reg_rd = rd; reg_addr = a; reg_wr = wr; reg_wdata = wd;
        #1;
        if (rd) check((tag == "") ? req_of(a) : tag, reg_rdata, exp_read(a));
        check("R10", {15'h0, irq}, {15'h0, |exp_sts()});
        ent[0] = '{sec: now_sec, nsec: now_nsec, seq: rx_seq};
        ent[1] = '{sec: now_sec, nsec: now_nsec, seq: tx_seq};
        capv[0] = rxc; capv[1] = txc;
        @(posedge clk); #1;
        for (int d = 0; d < NUM_DIR; d++) begin
            drp[d] = 1'b0;
            if (rd && a == ((d == 0) ? 4'h8 : 4'hD) && mq[d].size() > 0) void'(mq[d].pop_front());
            if (capv[d]) begin
                if (mq[d].size() < 8) mq[d].push_back(ent[d]);
                else drp[d] = 1'b1;
            end
        end
        if (rd && a == 4'h1) begin m_ovf[0] = 0; m_ovf[1] = 0; end
        for (int d = 0; d < NUM_DIR; d++) if (drp[d] && m_en[2*d+1]) m_ovf[d] = 1;
        if (wr && a == 4'h0) m_en = wd;
    endtask

    task automatic rd_reg(input string tag, input logic [3:0] a);
        step(tag, 0, 0, 1, a, 0, 4'h0);
    endtask

    initial begin
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);
        rst = 1; rx_cap = 0; tx_cap = 0; reg_rd = 0; reg_wr = 0;
        reg_addr = 0; reg_wdata = 0; rx_seq = 0; tx_seq = 0; now_sec = 0; now_nsec = 0;
        m_en = 0; m_ovf[0] = 0; m_ovf[1] = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        rd_reg("R1", 4'h0); rd_reg("R1", 4'h1); rd_reg("R1", 4'h2);
        rd_reg("R1", 4'h4); rd_reg("R1", 4'hD);
        // R5 empty sequence read does not pop
        rd_reg("R5", 4'h8); rd_reg("R5", 4'h2);
        // R7 enable write/read
        step("R7", 0, 0, 0, 4'h0, 1, 4'hF); rd_reg("R7", 4'h0);
        // R2/R3/R4/R11 receive entries, transmit untouched
        for (int i = 0; i < 3; i++) step("R2", 1, 0, 0, 4'h0, 0, 4'h0);
        rd_reg("R11", 4'h2);
        for (int a = 4; a <= 7; a++) rd_reg("R3", 4'(a));
        rd_reg("R4", 4'h4); rd_reg("R4", 4'h2);
        rd_reg("R4", 4'h8); rd_reg("R4", 4'h2);
        // R6 fill transmit, ninth capture dropped
        for (int i = 0; i < 9; i++) step("R6", 0, 1, 0, 4'h0, 0, 4'h0);
        rd_reg("R6", 4'h2); rd_reg("R6", 4'h1);
        rd_reg("R9", 4'h1);
        // R6 capture with pop of full queue accepted
        step("R6", 0, 1, 1, 4'hD, 0, 4'h0); rd_reg("R6", 4'h2); rd_reg("R6", 4'h1);
        // R9 drop on same edge as status read keeps flag
        step("R9", 0, 1, 1, 4'h1, 0, 4'h0); rd_reg("R9", 4'h1); rd_reg("R9", 4'h1);
        // drain transmit, then empty reads
        for (int i = 0; i < 9; i++) rd_reg("R4", 4'hD);
        rd_reg("R5", 4'h9); rd_reg("R5", 4'h2);
        // R8 available gated by enable
        step("R8", 0, 0, 0, 4'h0, 1, 4'h0); rd_reg("R8", 4'h1);
        step("R8", 0, 0, 0, 4'h0, 1, 4'h4); rd_reg("R8", 4'h1);
        step("R8", 0, 0, 0, 4'h0, 1, 4'h1); rd_reg("R8", 4'h1);

        // constrained random phase
        for (int i = 0; i < 4000; i++) begin
            bit rd, wr;
            logic [3:0] a;
            rd = ($urandom % 4) != 0;
            if ($urandom % 2) a = ($urandom % 2) ? 4'h8 : 4'hD;
            else a = 4'($urandom);
            wr = !rd && (($urandom % 8) == 0);
            if (wr) a = 4'h0;
            step("", ($urandom % 3) == 0, ($urandom % 3) == 0, rd, a, wr, 4'($urandom));
        end
        for (int a = 0; a < 16; a++) rd_reg("", 4'(a));

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule